// File: doc/BRIEF.md
# Tile Communication Instruction Sequencer

This block steps through a tile's communication program one instruction at a time. The program holds three kinds of instruction. A transmit reads a scratchpad entry and hands a packetized transfer to the on-chip network. A collect waits until a virtual channel holds enough packets, takes them, and allocates a scratchpad entry together with a reuse count. A stop waits until every compute core of the tile has stopped, and then freezes the tile.

The instruction memory and the scratchpad answer in the same cycle. All issue decisions are combinational on the current instruction, the inputs and two pieces of pacing state. The first is a shared memory-busy flag that makes both transmits and collects wait one cycle after any access. The second is an accumulator that adds a delay to each network transfer. The packet count of an instruction is the element count times 16 bits, rounded up to 32-bit packets, times the vector count.

Top module: `tile_comm_seq`

## Requirements
- R1: The 48-bit instruction word, from bit 47 down, holds: opcode (2 bits), virtual channel (6), element count (8), target tile or reuse count (16), vector count (8), scratchpad address (8). The opcodes are 00 transmit, 01 collect, and 10 or 11 stop.
- R2: The packet count reported on `net_pkts` and `rx_take_num` equals ceil(element_count/2) × vector_count.
- R3: In a non-root tile, a transmit with the memory idle raises `sp_acc_req` at its address. If `sp_acc_hit` is 1 the transfer is posted in that cycle (`net_vld`, with `net_dst`, `net_vch` and `net_pkts` taken from the word). If the access misses, nothing is posted and the program counter holds.
- R4: When the parameter TILE_ID is 0, a transmit never raises `sp_acc_req` and posts whenever the memory is idle, whatever `sp_acc_hit` is.
- R5: In the cycle after any posted transmit or accepted collect, no transmit or collect is issued.
- R6: The wait accumulator starts at 0. `net_wait` carries its current value. Each cycle the accumulator drops by 1 if it is nonzero, and it gains SEND_INC for each posted transmit.
- R7: A collect whose channel counter in `rx_cnt` is zero has no effect: no take, no allocation, no error, and the program counter holds.
- R8: A collect whose channel counter is nonzero but below the packet count raises `rx_err` and otherwise has no effect.
- R9: An accepted collect pulses `rx_take_vld` with its channel and packet count. In the same cycle it pulses `sp_alloc_vld` with the scratchpad address and the 16-bit reuse count.
- R10: The program counter `imem_addr` resets to 0. It increments by one exactly in the cycle after a posted transmit or an accepted collect.
- R11: A stop waits while `cores_halted` is not CORES. After the cycle in which it equals CORES, `halted` is 1 for good, the program counter is frozen, and no access, transfer or take follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | PC_W | Program counter, instruction memory address |
| imem_data | input | 48 | Instruction word at `imem_addr`, same cycle |
| sp_acc_req | output | 1 | Scratchpad read access for a transmit |
| sp_acc_addr | output | 8 | Scratchpad access address |
| sp_acc_hit | input | 1 | Access found a live entry and consumed one use |
| sp_alloc_vld | output | 1 | Scratchpad allocate strobe |
| sp_alloc_addr | output | 8 | Allocate address |
| sp_alloc_cnt | output | 16 | Reuse count for the new entry |
| net_vld | output | 1 | Network transfer posted |
| net_dst | output | 16 | Destination tile |
| net_vch | output | 6 | Virtual channel at the destination |
| net_pkts | output | 16 | Packets in the transfer |
| net_wait | output | WAIT_W | Extra wait cycles for the transfer |
| rx_cnt | input | NUM_VCH*CNT_W | Packet counters, channel i at bits i*CNT_W |
| rx_take_vld | output | 1 | Consume packets from a channel |
| rx_take_vch | output | 6 | Channel to consume from |
| rx_take_num | output | 16 | Packets to consume |
| rx_err | output | 1 | Collect asks for more packets than are present |
| cores_halted | input | CORE_W | Number of stopped compute cores |
| halted | output | 1 | Tile stopped |

## Verification
Every strobe (`net_vld`, `sp_acc_req`, `rx_take_vld`, `sp_alloc_vld`, `rx_err`) is combinational, so it is due in the same cycle as the instruction and inputs that cause it. The bench drives inputs just after the falling edge and samples 1 ns later. Program counter, busy gap, accumulator and `halted` are registered and appear one rising edge after the issue. The bench therefore checks the gap, the next address and the next `net_wait` at the following sample point, and it updates its arithmetic accumulator model once per edge. A packet-count sweep over 40 transmits covers element counts from 0 to 255 with varied vector counts.

// File: rtl/tcs_pkg.sv
// Shared field widths, opcode encoding, instruction layout and the
// packet-count function of the tile communication sequencer.
package tcs_pkg;
    localparam int OP_W    = 2;
    localparam int VT_W    = 6;
    localparam int WD_W    = 8;
    localparam int TC_W    = 16;
    localparam int VW_W    = 8;
    localparam int MA_W    = 8;
    localparam int INSTR_W = OP_W + VT_W + WD_W + TC_W + VW_W + MA_W;
    localparam int PK_W    = WD_W + VW_W;

    typedef enum logic [OP_W-1:0] {
        OP_XMIT  = 2'b00,
        OP_COLL  = 2'b01,
        OP_STOP  = 2'b10,
        OP_STOP2 = 2'b11
    } op_e;

    // Packed MSB-first, matching the word layout
    typedef struct packed {
        op_e             op;
        logic [VT_W-1:0] vch;
        logic [WD_W-1:0] elems;
        logic [TC_W-1:0] tgt;
        logic [VW_W-1:0] vecs;
        logic [MA_W-1:0] addr;
    } instr_t;

    // 16-bit elements packed two per 32-bit packet, times the vector count
    function automatic logic [PK_W-1:0] pkt_count(input logic [WD_W-1:0] e,
                                                  input logic [VW_W-1:0] v);
        logic [WD_W-1:0] half;
        half = {1'b0, e[WD_W-1:1]} + {{(WD_W-1){1'b0}}, e[0]};
        return PK_W'(half) * PK_W'(v);
    endfunction
endpackage

// File: rtl/tcs_decode.sv
// Splits an instruction word into its fields and computes its packet count.
// Assumes the word is valid in the same cycle as its address.
module tcs_decode
    import tcs_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output instr_t             ins,
    output logic [PK_W-1:0]    pkts
);
    // Field split and packet arithmetic
    always_comb begin
        ins  = instr_t'(word);
        pkts = pkt_count(ins.elems, ins.vecs);
    end
endmodule

// File: rtl/tcs_pacer.sv
// Holds the shared memory-busy flag (one blocked cycle after any access) and
// the cumulative transfer-wait accumulator. Assumes send_fire implies acc_fire.
module tcs_pacer #(
    parameter int WAIT_W   = 16,
    parameter int SEND_INC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_fire,
    input  logic              send_fire,
    output logic              busy,
    output logic [WAIT_W-1:0] wait_acc
);
    localparam logic [WAIT_W-1:0] INC = WAIT_W'(SEND_INC);

    logic [WAIT_W-1:0] decayed;

    // Accumulator after this cycle's decay
    always_comb begin
        decayed = (wait_acc != '0) ? wait_acc - 1'b1 : wait_acc;
    end

    // Busy flag and accumulator registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            wait_acc <= '0;
        end else begin
            busy     <= acc_fire;
            wait_acc <= decayed + (send_fire ? INC : '0);
        end
    end
endmodule

// File: rtl/tcs_issue.sv
// Decides in one cycle whether the current instruction transmits, collects,
// flags a short collect, stops, or stalls. Purely combinational.
module tcs_issue
    import tcs_pkg::*;
#(
    parameter int NUM_VCH = 8,
    parameter int CNT_W   = 16,
    parameter int CORES   = 4,
    parameter int CORE_W  = 3,
    parameter int TILE_ID = 1
) (
    input  instr_t                     ins,
    input  logic [PK_W-1:0]            pkts,
    input  logic                       busy,
    input  logic                       halted,
    input  logic                       sp_hit,
    input  logic [NUM_VCH*CNT_W-1:0]   rx_cnt,
    input  logic [CORE_W-1:0]          cores_halted,
    output logic                       sp_req,
    output logic                       send_fire,
    output logic                       recv_fire,
    output logic                       recv_short,
    output logic                       stop_fire
);
    localparam int CMP_W = (CNT_W > PK_W) ? CNT_W : PK_W;

    logic [CNT_W-1:0] avail;
    logic             send_go;
    logic             recv_go;
    logic             enough;

    // Select the counter of the addressed channel (out-of-range reads as zero)
    always_comb begin
        avail = '0;
        for (int i = 0; i < NUM_VCH; i++) begin
            if (ins.vch == VT_W'(i)) avail = rx_cnt[i*CNT_W +: CNT_W];
        end
    end

    // Common gating of transmit and collect
    always_comb begin
        send_go    = !halted && !busy && (ins.op == OP_XMIT);
        recv_go    = !halted && !busy && (ins.op == OP_COLL) && (avail != '0);
        enough     = CMP_W'(avail) >= CMP_W'(pkts);
        recv_fire  = recv_go && enough;
        recv_short = recv_go && !enough;
        stop_fire  = !halted && ((ins.op == OP_STOP) || (ins.op == OP_STOP2))
                     && (cores_halted == CORE_W'(CORES));
    end

    // Root tile transmits without a scratchpad lookup
    generate
        if (TILE_ID == 0) begin : g_root
            logic unused_hit;
            always_comb begin
                unused_hit = sp_hit;
                sp_req     = 1'b0;
                send_fire  = send_go;
            end
        end else begin : g_leaf
            always_comb begin
                sp_req    = send_go;
                send_fire = send_go && sp_hit;
            end
        end
    endgenerate
endmodule

// File: rtl/tile_comm_seq.sv
// In-order sequencer for a tile's transmit/collect/stop program. Instruction
// memory and scratchpad respond combinationally; outputs are strobes valid in
// the cycle of issue. Assumes the channel counters are reduced by the owner
// on rx_take_vld and the scratchpad consumes a use on a hit.
module tile_comm_seq
    import tcs_pkg::*;
#(
    parameter int PC_W     = 8,
    parameter int NUM_VCH  = 8,
    parameter int CNT_W    = 16,
    parameter int CORES    = 4,
    parameter int CORE_W   = $clog2(CORES + 1),
    parameter int TILE_ID  = 1,
    parameter int WAIT_W   = 16,
    parameter int SEND_INC = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [PC_W-1:0]          imem_addr,
    input  logic [47:0]              imem_data,
    output logic                     sp_acc_req,
    output logic [7:0]               sp_acc_addr,
    input  logic                     sp_acc_hit,
    output logic                     sp_alloc_vld,
    output logic [7:0]               sp_alloc_addr,
    output logic [15:0]              sp_alloc_cnt,
    output logic                     net_vld,
    output logic [15:0]              net_dst,
    output logic [5:0]               net_vch,
    output logic [15:0]              net_pkts,
    output logic [WAIT_W-1:0]        net_wait,
    input  logic [NUM_VCH*CNT_W-1:0] rx_cnt,
    output logic                     rx_take_vld,
    output logic [5:0]               rx_take_vch,
    output logic [15:0]              rx_take_num,
    output logic                     rx_err,
    input  logic [CORE_W-1:0]        cores_halted,
    output logic                     halted
);
    instr_t            ins;
    logic [PK_W-1:0]   pkts;
    logic              busy;
    logic              send_fire;
    logic              recv_fire;
    logic              stop_fire;
    logic [PC_W-1:0]   pc;

    tcs_decode u_dec (
        .word (imem_data),
        .ins  (ins),
        .pkts (pkts)
    );

    tcs_issue #(
        .NUM_VCH (NUM_VCH),
        .CNT_W   (CNT_W),
        .CORES   (CORES),
        .CORE_W  (CORE_W),
        .TILE_ID (TILE_ID)
    ) u_iss (
        .ins          (ins),
        .pkts         (pkts),
        .busy         (busy),
        .halted       (halted),
        .sp_hit       (sp_acc_hit),
        .rx_cnt       (rx_cnt),
        .cores_halted (cores_halted),
        .sp_req       (sp_acc_req),
        .send_fire    (send_fire),
        .recv_fire    (recv_fire),
        .recv_short   (rx_err),
        .stop_fire    (stop_fire)
    );

    tcs_pacer #(
        .WAIT_W   (WAIT_W),
        .SEND_INC (SEND_INC)
    ) u_pace (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_fire  (send_fire || recv_fire),
        .send_fire (send_fire),
        .busy      (busy),
        .wait_acc  (net_wait)
    );

    // Program counter and stop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            halted <= 1'b0;
        end else begin
            if (send_fire || recv_fire) pc <= pc + 1'b1;
            if (stop_fire)              halted <= 1'b1;
        end
    end

    // Output field routing
    always_comb begin
        imem_addr     = pc;
        sp_acc_addr   = ins.addr;
        net_vld       = send_fire;
        net_dst       = ins.tgt;
        net_vch       = ins.vch;
        net_pkts      = pkts;
        rx_take_vld   = recv_fire;
        rx_take_vch   = ins.vch;
        rx_take_num   = pkts;
        sp_alloc_vld  = recv_fire;
        sp_alloc_addr = ins.addr;
        sp_alloc_cnt  = ins.tgt;
    end
endmodule

// File: rtl/tcs_checker.sv
// Temporal properties of tile_comm_seq, observed at its ports and outputs.
module tcs_checker #(
    parameter int PC_W    = 8,
    parameter int CORES   = 4,
    parameter int CORE_W  = 3,
    parameter int TILE_ID = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   imem_addr,
    input logic              sp_acc_req,
    input logic              sp_acc_hit,
    input logic              net_vld,
    input logic              rx_take_vld,
    input logic              sp_alloc_vld,
    input logic              rx_err,
    input logic [CORE_W-1:0] cores_halted,
    input logic              halted
);
    a_r5_gap_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        (net_vld || rx_take_vld) |=> !(net_vld || rx_take_vld));

    a_r10_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (net_vld || rx_take_vld) |=> imem_addr == $past(imem_addr) + 1'b1);

    a_r10_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(net_vld || rx_take_vld) |=> $stable(imem_addr));

    a_r11_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(imem_addr));

    a_r11_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(net_vld || rx_take_vld || sp_acc_req || rx_err));

    a_r11_stop_needs_cores: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(cores_halted) == CORE_W'(CORES));

    a_r8_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> !rx_take_vld && !sp_alloc_vld);

    a_r9_take_with_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take_vld |-> sp_alloc_vld && !net_vld);

    a_r3_post_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (net_vld && (TILE_ID != 0)) |-> sp_acc_req && sp_acc_hit);
endmodule

bind tile_comm_seq tcs_checker #(
    .PC_W    (PC_W),
    .CORES   (CORES),
    .CORE_W  (CORE_W),
    .TILE_ID (TILE_ID)
) u_tcs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .imem_addr    (imem_addr),
    .sp_acc_req   (sp_acc_req),
    .sp_acc_hit   (sp_acc_hit),
    .net_vld      (net_vld),
    .rx_take_vld  (rx_take_vld),
    .sp_alloc_vld (sp_alloc_vld),
    .rx_err       (rx_err),
    .cores_halted (cores_halted),
    .halted       (halted)
);

// File: tb/tile_comm_seq_bench.sv
`timescale 1ns/1ps
module tile_comm_seq_bench;
    localparam int PC_W = 6;
    localparam int NV   = 8;
    localparam int CW   = 16;
    localparam int NC   = 4;
    localparam int CRW  = 3;
    localparam int INC  = 3;
    localparam int K    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int acc_m  = 0;

    // main (non-root) instance signals
    logic [47:0]      prog [0:63];
    logic [PC_W-1:0]  imem_addr;
    logic [47:0]      imem_data;
    logic             sp_acc_req, sp_acc_hit, sp_alloc_vld;
    logic [7:0]       sp_acc_addr, sp_alloc_addr;
    logic [15:0]      sp_alloc_cnt, net_dst, net_pkts, rx_take_num;
    logic             net_vld, rx_take_vld, rx_err, halted;
    logic [5:0]       net_vch, rx_take_vch;
    logic [15:0]      net_wait;
    logic [NV*CW-1:0] rx_cnt;
    logic [CRW-1:0]   cores_halted;

    assign imem_data = prog[imem_addr];

    tile_comm_seq #(.PC_W(PC_W), .NUM_VCH(NV), .CNT_W(CW), .CORES(NC),
                    .TILE_ID(1), .WAIT_W(16), .SEND_INC(INC)) u_tile_comm_seq (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .sp_acc_req(sp_acc_req), .sp_acc_addr(sp_acc_addr), .sp_acc_hit(sp_acc_hit),
        .sp_alloc_vld(sp_alloc_vld), .sp_alloc_addr(sp_alloc_addr),
        .sp_alloc_cnt(sp_alloc_cnt), .net_vld(net_vld), .net_dst(net_dst),
        .net_vch(net_vch), .net_pkts(net_pkts), .net_wait(net_wait),
        .rx_cnt(rx_cnt), .rx_take_vld(rx_take_vld), .rx_take_vch(rx_take_vch),
        .rx_take_num(rx_take_num), .rx_err(rx_err),
        .cores_halted(cores_halted), .halted(halted));

    // root instance signals
    logic [47:0]      rprog [0:3];
    logic [1:0]       r_addr;
    logic [47:0]      r_data;
    logic             r_req, r_avld, r_nvld, r_tvld, r_err, r_halted;
    logic [7:0]       r_aaddr, r_laddr;
    logic [15:0]      r_lcnt, r_dst, r_pkts, r_tnum, r_wait;
    logic [5:0]       r_vch, r_tvch;

    assign r_data = rprog[r_addr];

    tile_comm_seq #(.PC_W(2), .NUM_VCH(NV), .CNT_W(CW), .CORES(NC),
                    .TILE_ID(0), .WAIT_W(16), .SEND_INC(1)) u_root (
        .clk(clk), .rst_n(rst_n), .imem_addr(r_addr), .imem_data(r_data),
        .sp_acc_req(r_req), .sp_acc_addr(r_aaddr), .sp_acc_hit(1'b0),
        .sp_alloc_vld(r_avld), .sp_alloc_addr(r_laddr), .sp_alloc_cnt(r_lcnt),
        .net_vld(r_nvld), .net_dst(r_dst), .net_vch(r_vch), .net_pkts(r_pkts),
        .net_wait(r_wait), .rx_cnt('0), .rx_take_vld(r_tvld),
        .rx_take_vch(r_tvch), .rx_take_num(r_tnum), .rx_err(r_err),
        .cores_halted(3'(NC)), .halted(r_halted));

    function automatic logic [47:0] mk(input int op, input int vt, input int wd,
                                       input int tc, input int vw, input int ma);
        return {2'(op), 6'(vt), 8'(wd), 16'(tc), 8'(vw), 8'(ma)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance one edge, update the accumulator model, settle inputs window
    task automatic adv(input bit fired);
        @(posedge clk);
        acc_m = ((acc_m > 0) ? acc_m - 1 : 0) + (fired ? INC : 0);
        @(negedge clk);
    endtask

    function automatic int wd_of(input int i); return (i * 13 + (i % 2)) % 256; endfunction
    function automatic int vw_of(input int i); return (i * 29 + 1) % 256; endfunction

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) prog[i] = mk(0, 0, 2, 0, 1, 0);
        for (int i = 0; i < K; i++)
            prog[i] = mk(0, i % 64, wd_of(i), i * 7 + 100, vw_of(i), (i * 3) % 256);
        prog[K]     = mk(1, 2, 4, 5, 3, 8'h33);   // 6 packets
        prog[K + 1] = mk(1, 5, 3, 9, 1, 8'h44);   // 2 packets
        prog[K + 2] = mk(0, 1, 2, 77, 1, 8'h55);
        prog[K + 3] = mk(2, 0, 0, 0, 0, 0);
        rprog[0] = mk(0, 1, 2, 3, 1, 0);
        rprog[1] = mk(0, 1, 2, 3, 1, 0);
        rprog[2] = mk(3, 0, 0, 0, 0, 0);
        rprog[3] = mk(0, 1, 2, 3, 1, 0);
        sp_acc_hit = 1'b0; rx_cnt = '0; cores_halted = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // miss stall on main, root runs: cycles 0..4
        for (int c = 0; c < 5; c++) begin
            #1;
            if (c == 0) begin
                chk(imem_addr == 0 && !halted, "R10 reset pc/halted", imem_addr, 0);
                chk(net_wait == 0, "R6 reset accumulator", net_wait, 0);
            end
            chk(sp_acc_req && sp_acc_addr == 0, "R3 access request on miss", sp_acc_req, 1);
            chk(!net_vld && imem_addr == 0, "R3 miss stalls", imem_addr, 0);
            chk(r_nvld == (c == 0 || c == 2), "R4 root posts without lookup", r_nvld, (c == 0 || c == 2));
            chk(!r_req, "R4 root no access", r_req, 0);
            chk(r_halted == (c >= 4), "R1 opcode 11 stops", r_halted, c >= 4);
            adv(1'b0);
        end

        // packet-count sweep over transmits
        sp_acc_hit = 1'b1;
        for (int i = 0; i < K; i++) begin
            int ep;
            ep = ((wd_of(i) + 1) / 2) * vw_of(i);
            #1;
            chk(net_vld && imem_addr == i, "R3 transmit posts", net_vld, 1);
            chk(net_pkts == ep, "R2 packet count", net_pkts, ep);
            chk(net_dst == 16'(i * 7 + 100) && net_vch == 6'(i % 64)
                && sp_acc_addr == 8'((i * 3) % 256), "R1 fields", net_dst, i * 7 + 100);
            chk(net_wait == acc_m, "R6 wait accumulator", net_wait, acc_m);
            adv(1'b1);
            #1;
            chk(!net_vld && !sp_acc_req, "R5 busy gap", net_vld, 0);
            chk(imem_addr == i + 1, "R10 pc step", imem_addr, i + 1);
            adv(1'b0);
        end

        // collect on channel 2: empty, short, exact
        for (int c = 0; c < 2; c++) begin
            #1;
            chk(!rx_take_vld && !sp_alloc_vld && !rx_err && imem_addr == K,
                "R7 empty channel stalls", rx_take_vld, 0);
            adv(1'b0);
        end
        rx_cnt[2*CW +: CW] = 16'd4;
        #1;
        chk(rx_err && !rx_take_vld && !sp_alloc_vld, "R8 short collect flags", rx_err, 1);
        adv(1'b0);
        #1;
        chk(imem_addr == K, "R8 short collect holds pc", imem_addr, K);
        rx_cnt[2*CW +: CW] = 16'd6;
        #1;
        chk(rx_take_vld && rx_take_num == 6 && rx_take_vch == 2 && !rx_err,
            "R9 collect takes", rx_take_num, 6);
        chk(sp_alloc_vld && sp_alloc_addr == 8'h33 && sp_alloc_cnt == 5,
            "R9 allocate", sp_alloc_cnt, 5);
        adv(1'b0);
        rx_cnt[2*CW +: CW] = 16'd0;
        rx_cnt[5*CW +: CW] = 16'd9;
        #1;
        chk(!rx_take_vld && imem_addr == K + 1, "R5 busy gap after collect", rx_take_vld, 0);
        adv(1'b0);
        #1;
        chk(rx_take_vld && rx_take_num == 2 && rx_take_vch == 5, "R9 second collect", rx_take_num, 2);
        adv(1'b0);
        rx_cnt[5*CW +: CW] = 16'd7;
        adv(1'b0);

        // transmit miss then hit
        sp_acc_hit = 1'b0;
        #1;
        chk(sp_acc_req && !net_vld && imem_addr == K + 2, "R3 miss no post", net_vld, 0);
        chk(sp_acc_addr == 8'h55, "R3 access address", sp_acc_addr, 8'h55);
        adv(1'b0);
        sp_acc_hit = 1'b1;
        #1;
        chk(net_vld && net_dst == 77, "R3 hit posts", net_dst, 77);
        adv(1'b1);
        adv(1'b0);

        // stop waits for all cores
        cores_halted = 3'd3;
        for (int c = 0; c < 2; c++) begin
            #1;
            chk(!halted && imem_addr == K + 3, "R11 stop waits", halted, 0);
            adv(1'b0);
        end
        cores_halted = 3'd4;
        adv(1'b0);
        cores_halted = 3'd0;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(halted && imem_addr == K + 3, "R11 stopped and frozen", imem_addr, K + 3);
            chk(!sp_acc_req && !net_vld && !rx_take_vld, "R11 no further action", net_vld, 0);
            adv(1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule